// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines and offers one interrupt output to a processor. Requests are latched in a request register, held back by a mask register, and ranked by a priority resolver whose order can be rotated. When the processor pulses the acknowledge input, the winning request moves into the in-service register and an 8-bit vector (programmed base plus line number) is presented in the same cycle. In-service bits block requests of equal or lower priority until they are cleared, either by an end-of-interrupt command or automatically at acknowledge time.

Software reaches the block through two byte-wide addresses: a command address (`bus_addr` = 0) and a data address (`bus_addr` = 1). An initialization word written to the command address starts a sequence handled by a small state machine with four states: READY, WAIT_BASE, WAIT_CASC and WAIT_MODE. Its transitions are: any state goes to WAIT_BASE on an initialization word; WAIT_BASE goes to WAIT_CASC on a data write (vector base loaded); WAIT_CASC goes to WAIT_MODE on a data write when a mode word was requested, otherwise to READY (cascade word loaded); WAIT_MODE goes to READY on a data write (mode word loaded). In READY, data writes load the mask and command writes act as control commands. The cascade word is only stored for read-back. On a master it is a one-hot map of the inputs that carry a slave, for example 0x04 for input 2. On a slave it is the binary number of the master input it uses, for example 2. For a cascaded interrupt, software issues end-of-interrupt to the slave first and then to the master.

Top module: `prio_intc`

## Requirements
- R1: After reset the interrupt output is low, the mask reads 0xFF at the data address, and the command address reads a request register of 0x00.
- R2: A command write with bit 4 set is an initialization word (bit 0 = a mode word follows, bit 3 = level mode). It clears the request and in-service registers, sets the mask to 0xFF, sets the lowest priority to line 7 and selects request-register reads. The next data writes load the vector base, then the cascade word, then the mode word if it was requested. Every data write after that loads the mask.
- R3: On an acknowledge pulse with a pending winner, vector_o equals the vector base plus the winning line number during that cycle. The winner's in-service bit is set unless automatic end-of-interrupt is on.
- R4: A read-select command (bit 4 = 0, bit 3 = 1) with bits[1:0] = 01 makes command-address reads return the stored cascade word.
- R5: Mask bit i set keeps line i from raising the interrupt output. Its request is still latched and visible in the request register.
- R6: Read-select bits[1:0] = 11 switches command-address reads to the in-service register, and 10 switches them back to the request register. The selection persists between reads.
- R7: Command 0x20 (non-specific end-of-interrupt) clears only the highest-priority set in-service bit.
- R8: Mode word bit 1 enables automatic end-of-interrupt: acknowledge then sets no in-service bit.
- R9: Command 0xC0 | L makes line L the lowest priority, so the order runs L+1 upward around to L. After 0xC2, line 3 beats line 0.
- R10: In edge mode a request is latched only on a rising input, is held after the input falls, and is not re-latched while the input stays high after acknowledge. In level mode the request follows the input and clears when it falls.
- R11: An acknowledge with no eligible request returns the vector base plus 7 and sets no in-service bit.
- R12: The interrupt output is high only when an unmasked request outranks every set in-service bit. A request of lower priority than a bit in service stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = command address, 1 = data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from bus_addr) |
| irq_in | input | 8 | Interrupt request lines |
| int_o | output | 1 | Interrupt to the processor |
| inta | input | 1 | Single-cycle acknowledge pulse |
| vector_o | output | 8 | Vector, valid while inta is high |

## Verification
The hardest situation to reach from the ports is the spurious acknowledge. It needs a request that is seen and then vanishes before the acknowledge arrives. The stimulus reinitializes in level mode, raises and drops a line, and then pulses acknowledge into an empty resolver. Nested service is reached by acknowledging a low-priority line, raising both a lower and a higher one, and then stepping end-of-interrupt commands while reading the in-service register between them.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic [1:0] {
        ST_READY,
        ST_WAIT_BASE,
        ST_WAIT_CASC,
        ST_WAIT_MODE
    } seq_state_e;

    typedef enum logic [1:0] {
        RS_REQ,
        RS_SVC,
        RS_CASC
    } rd_sel_e;

    localparam int unsigned INIT_BIT    = 4;
    localparam int unsigned SEL_BIT     = 3;
    localparam int unsigned LEVEL_BIT   = 3;
    localparam int unsigned MODEREQ_BIT = 0;
    localparam int unsigned AEOI_BIT    = 1;
    localparam logic [2:0]  OP_EOI      = 3'b001;
    localparam logic [2:0]  OP_SETPRI   = 3'b110;
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic          data_wr,
    input  logic [DW-1:0] wdata,
    output logic          init_start,
    output logic          ready,
    output logic          load_base,
    output logic          load_casc,
    output logic          load_mode,
    output logic          load_mask
);
    seq_state_e state_q, state_d;
    logic       mode_req_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          mode_req_q <= 1'b0;
        else if (init_start) mode_req_q <= wdata[MODEREQ_BIT];
    end

    always_comb begin
        init_start = cmd_wr & wdata[INIT_BIT];
        state_d    = state_q;
        load_base  = 1'b0;
        load_casc  = 1'b0;
        load_mode  = 1'b0;
        load_mask  = 1'b0;
        unique case (state_q)
            ST_READY: begin
                if (data_wr) load_mask = 1'b1;
            end
            ST_WAIT_BASE: begin
                if (data_wr) begin
                    load_base = 1'b1;
                    state_d   = ST_WAIT_CASC;
                end
            end
            ST_WAIT_CASC: begin
                if (data_wr) begin
                    load_casc = 1'b1;
                    state_d   = mode_req_q ? ST_WAIT_MODE : ST_READY;
                end
            end
            ST_WAIT_MODE: begin
                if (data_wr) begin
                    load_mode = 1'b1;
                    state_d   = ST_READY;
                end
            end
            default: state_d = ST_READY;
        endcase
        if (init_start) state_d = ST_WAIT_BASE;
        ready = (state_q == ST_READY);
    end
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    input  logic         level_mode,
    input  logic         clr_all,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] irr
);
    for (genvar g = 0; g < N; g++) begin : g_line
        logic prev_q;
        logic req_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                req_q  <= 1'b0;
            end else begin
                prev_q <= irq_in[g];
                if (clr_all)                     req_q <= 1'b0;
                else if (level_mode)             req_q <= irq_in[g];
                else if (irq_in[g] && !prev_q)   req_q <= 1'b1;
                else if (ack_clr[g])             req_q <= 1'b0;
            end
        end
        assign irr[g] = req_q;
    end
endmodule

// File: rtl/pic_prio_res.sv
module pic_prio_res #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  isr,
    input  logic [IW-1:0] low,
    output logic          grant_valid,
    output logic [IW-1:0] grant_idx,
    output logic          top_valid,
    output logic [IW-1:0] top_idx
);
    logic [IW-1:0] line_a, line_b;
    logic          blocked;

    always_comb begin
        grant_valid = 1'b0;
        grant_idx   = '0;
        blocked     = 1'b0;
        line_a      = '0;
        for (int k = 0; k < N; k++) begin
            line_a = low + IW'(1) + IW'(k);
            if (!grant_valid && !blocked) begin
                if (isr[line_a])      blocked = 1'b1;
                else if (req[line_a]) begin
                    grant_valid = 1'b1;
                    grant_idx   = line_a;
                end
            end
        end
    end

    always_comb begin
        top_valid = 1'b0;
        top_idx   = '0;
        line_b    = '0;
        for (int k = 0; k < N; k++) begin
            line_b = low + IW'(1) + IW'(k);
            if (!top_valid && isr[line_b]) begin
                top_valid = 1'b1;
                top_idx   = line_b;
            end
        end
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import pic_pkg::*;
#(
    parameter int unsigned N_LINES = 8,
    parameter int unsigned DW      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [N_LINES-1:0] irq_in,
    output logic               int_o,
    input  logic               inta,
    output logic [DW-1:0]      vector_o
);
    localparam int unsigned   IW   = $clog2(N_LINES);
    localparam logic [IW-1:0] LAST = IW'(N_LINES - 1);

    logic cmd_wr, data_wr, init_start, ready;
    logic load_base, load_casc, load_mode, load_mask;

    assign cmd_wr  = bus_wr & ~bus_addr;
    assign data_wr = bus_wr &  bus_addr;

    pic_init_seq #(.DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr),
        .wdata(bus_wdata), .init_start(init_start), .ready(ready),
        .load_base(load_base), .load_casc(load_casc),
        .load_mode(load_mode), .load_mask(load_mask)
    );

    logic [DW-1:0]      base_q, casc_q;
    logic               aeoi_q, level_q;
    logic [N_LINES-1:0] mask_q, isr_q, isr_d, irr, ack_clr;
    logic [IW-1:0]      low_q;
    rd_sel_e            rsel_q;

    logic          grant_valid, top_valid, grant, ctl_wr, do_eoi, do_setpri;
    logic [IW-1:0] grant_idx, top_idx;

    assign ctl_wr    = cmd_wr & ready & ~bus_wdata[INIT_BIT];
    assign do_eoi    = ctl_wr & ~bus_wdata[SEL_BIT] & (bus_wdata[7:5] == OP_EOI);
    assign do_setpri = ctl_wr & ~bus_wdata[SEL_BIT] & (bus_wdata[7:5] == OP_SETPRI);
    assign grant     = inta & grant_valid;

    always_comb begin
        ack_clr = '0;
        if (grant) ack_clr[grant_idx] = 1'b1;
    end

    pic_req_latch #(.N(N_LINES)) u_req (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(level_q),
        .clr_all(init_start), .ack_clr(ack_clr), .irr(irr)
    );

    pic_prio_res #(.N(N_LINES), .IW(IW)) u_res (
        .req(irr & ~mask_q), .isr(isr_q), .low(low_q),
        .grant_valid(grant_valid), .grant_idx(grant_idx),
        .top_valid(top_valid), .top_idx(top_idx)
    );

    always_comb begin
        isr_d = isr_q;
        if (init_start) isr_d = '0;
        else begin
            if (grant && !aeoi_q)   isr_d[grant_idx] = 1'b1;
            if (do_eoi && top_valid) isr_d[top_idx]  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            casc_q  <= '0;
            aeoi_q  <= 1'b0;
            level_q <= 1'b0;
            mask_q  <= '1;
            isr_q   <= '0;
            low_q   <= LAST;
            rsel_q  <= RS_REQ;
        end else begin
            isr_q <= isr_d;
            if (init_start) begin
                level_q <= bus_wdata[LEVEL_BIT];
                aeoi_q  <= 1'b0;
                mask_q  <= '1;
                low_q   <= LAST;
                rsel_q  <= RS_REQ;
            end
            if (load_base) base_q <= bus_wdata;
            if (load_casc) casc_q <= bus_wdata;
            if (load_mode) aeoi_q <= bus_wdata[AEOI_BIT];
            if (load_mask) mask_q <= bus_wdata[N_LINES-1:0];
            if (do_setpri) low_q  <= bus_wdata[IW-1:0];
            if (ctl_wr && bus_wdata[SEL_BIT]) begin
                unique case (bus_wdata[1:0])
                    2'b10:   rsel_q <= RS_REQ;
                    2'b11:   rsel_q <= RS_SVC;
                    2'b01:   rsel_q <= RS_CASC;
                    default: rsel_q <= rsel_q;
                endcase
            end
        end
    end

    assign int_o    = grant_valid;
    assign vector_o = base_q + DW'(grant_valid ? grant_idx : LAST);

    always_comb begin
        if (bus_addr) bus_rdata = DW'(mask_q);
        else begin
            unique case (rsel_q)
                RS_SVC:  bus_rdata = DW'(isr_q);
                RS_CASC: bus_rdata = casc_q;
                default: bus_rdata = DW'(irr);
            endcase
        end
    end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
    parameter int unsigned N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_wr,
    input logic         bus_addr,
    input logic [7:0]   bus_wdata,
    input logic         inta,
    input logic         int_o,
    input logic [N-1:0] irr,
    input logic [N-1:0] req_mask,
    input logic [N-1:0] isr,
    input logic         aeoi,
    input logic         ready
);
    a_r3_ack_sets_one: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && int_o && !aeoi && !bus_wr) |=> $countones(isr) == $countones($past(isr)) + 1);

    a_r7_eoi_clears_one: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata == 8'h20 && ready && !inta)
        |=> ($countones(isr) + (($past(isr) != '0) ? 1 : 0)) == $countones($past(isr)));

    a_r8_aeoi_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && aeoi && !bus_wr) |=> isr == $past(isr));

    a_r11_spurious_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !int_o && !bus_wr) |=> isr == $past(isr));

    a_r12_int_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> (irr & ~req_mask) != '0);
endmodule

bind prio_intc prio_intc_chk #(.N(N_LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .inta(inta), .int_o(int_o), .irr(irr),
    .req_mask(mask_q), .isr(isr_q), .aeoi(aeoi_q), .ready(ready)
);

// File: tb/prio_intc_bench.sv
`timescale 1ns/1ps
module prio_intc_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] irq_in = '0;
    logic       int_o;
    logic       inta = 1'b0;
    logic [7:0] vector_o;
    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    prio_intc u_prio_intc (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .int_o(int_o), .inta(inta), .vector_o(vector_o)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ack(output logic [7:0] v);
        @(negedge clk);
        inta = 1'b1;
        #1 v = vector_o;
        @(negedge clk);
        inta = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk({7'd0, int_o}, 8'h00, "R1 int low");
        rd(1'b1, d); chk(d, 8'hFF, "R1 mask");
        rd(1'b0, d); chk(d, 8'h00, "R1 request reg");
    endtask

    task automatic t_init_master();
        logic [7:0] d;
        wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h00);
        rd(1'b1, d); chk(d, 8'hFF, "R2 mode word not mask");
        wr(1, 8'hF7);
        rd(1'b1, d); chk(d, 8'hF7, "R2 mask after sequence");
        wr(0, 8'h09); rd(1'b0, d); chk(d, 8'h04, "R4 cascade readback");
        wr(0, 8'h0A);
    endtask

    task automatic t_mask_vector();
        logic [7:0] d, v;
        irq_in = 8'h20; tick();
        chk({7'd0, int_o}, 8'h00, "R5 masked no int");
        rd(1'b0, d); chk(d, 8'h20, "R5 masked still latched");
        irq_in = 8'h28; tick();
        chk({7'd0, int_o}, 8'h01, "R5 unmasked raises int");
        ack(v); chk(v, 8'h23, "R3 vector base+3");
        irq_in = 8'h00;
        wr(0, 8'h0B); rd(1'b0, d); chk(d, 8'h08, "R6 isr select");
        wr(0, 8'h20); rd(1'b0, d); chk(d, 8'h00, "R7 eoi single");
        wr(0, 8'h0A); rd(1'b0, d); chk(d, 8'h20, "R6 back to request");
    endtask

    task automatic t_nesting();
        logic [7:0] d, v;
        wr(1, 8'h00);
        chk({7'd0, int_o}, 8'h01, "R12 pending line 5");
        ack(v); chk(v, 8'h25, "R3 vector base+5");
        irq_in = 8'h80; tick();
        chk({7'd0, int_o}, 8'h00, "R12 lower blocked");
        irq_in = 8'h82; tick();
        chk({7'd0, int_o}, 8'h01, "R12 higher nests");
        ack(v); chk(v, 8'h21, "R3 vector base+1");
        wr(0, 8'h0B); rd(1'b0, d); chk(d, 8'h22, "R6 two in service");
        wr(0, 8'h20); rd(1'b0, d); chk(d, 8'h20, "R7 highest cleared first");
        chk({7'd0, int_o}, 8'h00, "R12 line 7 under line 5");
        wr(0, 8'h20); rd(1'b0, d); chk(d, 8'h00, "R7 second eoi");
        chk({7'd0, int_o}, 8'h01, "R12 line 7 released");
        ack(v); chk(v, 8'h27, "R3 vector base+7 real");
        wr(0, 8'h20); irq_in = 8'h00;
        wr(0, 8'h0A);
    endtask

    task automatic t_rotate();
        logic [7:0] v;
        wr(0, 8'hC2);
        irq_in = 8'h09; tick();
        ack(v); chk(v, 8'h23, "R9 line 3 beats 0");
        wr(0, 8'h20);
        ack(v); chk(v, 8'h20, "R9 line 0 next");
        wr(0, 8'h20); irq_in = 8'h00;
        wr(0, 8'hC7);
    endtask

    task automatic t_edge();
        logic [7:0] d, v;
        irq_in = 8'h10; tick();
        ack(v); chk(v, 8'h24, "R10 edge ack");
        wr(0, 8'h20); tick(); tick(); tick();
        chk({7'd0, int_o}, 8'h00, "R10 no relatch while high");
        rd(1'b0, d); chk(d, 8'h00, "R10 request clear while high");
        irq_in = 8'h40; tick(); irq_in = 8'h00; tick();
        rd(1'b0, d); chk(d, 8'h40, "R10 edge held after drop");
        chk({7'd0, int_o}, 8'h01, "R10 edge int held");
        ack(v); wr(0, 8'h20);
    endtask

    task automatic t_level_spurious();
        logic [7:0] d, v;
        wr(0, 8'h18); wr(1, 8'h40); wr(1, 8'h02); wr(1, 8'h5A);
        rd(1'b1, d); chk(d, 8'h5A, "R2 no mode word, mask loaded");
        rd(1'b0, d); chk(d, 8'h00, "R2 request cleared by init");
        wr(0, 8'h09); rd(1'b0, d); chk(d, 8'h02, "R4 slave cascade");
        wr(0, 8'h0A); wr(1, 8'h00);
        irq_in = 8'h10; tick();
        rd(1'b0, d); chk(d, 8'h10, "R10 level follows high");
        irq_in = 8'h00; tick();
        rd(1'b0, d); chk(d, 8'h00, "R10 level clears on drop");
        chk({7'd0, int_o}, 8'h00, "R10 level int drops");
        irq_in = 8'h10; tick(); irq_in = 8'h00; tick();
        ack(v); chk(v, 8'h47, "R11 spurious vector");
        wr(0, 8'h0B); rd(1'b0, d); chk(d, 8'h00, "R11 no in-service bit");
        wr(0, 8'h0A);
    endtask

    task automatic t_aeoi();
        logic [7:0] d, v;
        wr(0, 8'h11); wr(1, 8'h08); wr(1, 8'h04); wr(1, 8'h02); wr(1, 8'h00);
        irq_in = 8'h04; tick();
        ack(v); chk(v, 8'h0A, "R8 vector");
        wr(0, 8'h0B); rd(1'b0, d); chk(d, 8'h00, "R8 auto eoi isr empty");
        chk({7'd0, int_o}, 8'h00, "R8 int low after ack");
        irq_in = 8'h00;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_init_master();
        t_mask_vector();
        t_nesting();
        t_rotate();
        t_edge();
        t_level_spurious();
        t_aeoi();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule